// File: doc/BRIEF.md
# System I/O Control Register Bank

This block is a byte-wide, port-mapped register file for a legacy workstation I/O bus. It compares a 16-bit port address against a small set of fixed ports and serves single-byte reads and writes. Some ports hold state. Some return strap values taken from configuration inputs. Some accept writes and do nothing with them. Two writes have side effects: one drives a soft-reset output and one drives an output that selects a non-contiguous I/O map. A write that asks for little-endian operation is not supported. It raises a sticky error flag instead of taking effect.

Bit numbering follows big-endian convention: architectural bit n of a register is the byte mask `1 << (7-n)`, so architectural bit 7 is the least significant bit. Each register filters writes through its own mask. Register state changes on the clock edge that accepts a write, so the side-effect outputs change in the following cycle. Read data is combinational in the cycle the read is requested.

A separate 32-bit memory-mapped status word answers full-width reads at one aligned address and always returns zero. The reset is asynchronous and active low. It is released through a two-stage synchroniser, so the registers leave reset two clock edges after the reset input rises.

Top module: `sysio_regbank`

## Requirements
- R1: While reset is applied and after it, the outputs are `soft_rst`=0, `le_err`=0 and `map_noncontig`=1. Port 0x092 reads 0x00, port 0x81C reads 0x00 and port 0x850 reads 0x01.
- R2: A write to port 0x092 stores data bit 0 (mask 0x01, soft reset). From the cycle after the write, `soft_rst` equals that bit. A read of 0x092 returns `{7'b0, stored bit}`.
- R3: A write to port 0x092 with data bit 1 set (mask 0x02, little-endian request) sets `le_err` from the next cycle. `le_err` then stays set until reset. The bit is never stored, so a read of 0x092 shows only bit 0.
- R4: A write to port 0x81C stores the data masked with 0xF0. Bit 4 is floppy motor inhibit, bit 5 masks transfer error, bit 6 inhibits L2 update and bit 7 inhibits L2 miss handling. A read returns the stored byte, so bits 3:0 always read 0.
- R5: A write to port 0x850 stores data bit 0 (mask 0x01). From the next cycle, `map_noncontig` equals that bit. A read of 0x850 returns `{7'b0, stored bit}`.
- R6: Port 0x80C returns `cfg_equip` and port 0x852 returns `cfg_board_id`. Writes to either port change no register and no output.
- R7: Port 0x818 always reads 0x00. Writes to it change no register and no output.
- R8: Ports 0x808, 0x810, 0x812 and 0x814 are write-only. Writes to them change no register and no output, and reads of them return 0xFF.
- R9: Any other port reads 0xFF. Writes to it are ignored and do not set `le_err`.
- R10: `mem_hit` is 1 exactly when `mem_rd` is 1, `mem_addr` equals 0xBFFFEFF0 and `mem_be` is 4'hF. `mem_rdata` is always 0.
- R11: `io_rdata` is 0x00 whenever `io_rd` is 0. When `io_rd` is 1, it shows the addressed value in the same cycle, taken from the register state before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Byte read strobe |
| io_wr | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data |
| cfg_equip | input | 8 | Equipment strap value |
| cfg_board_id | input | 8 | Board identification strap value |
| mem_addr | input | 32 | Memory-mapped read address |
| mem_rd | input | 1 | Memory-mapped read strobe |
| mem_be | input | 4 | Byte enables of the memory read |
| mem_rdata | output | 32 | Memory-mapped read data (always zero) |
| mem_hit | output | 1 | Valid full-width read of the status word |
| soft_rst | output | 1 | Registered soft-reset request |
| map_noncontig | output | 1 | Registered non-contiguous I/O map select |
| le_err | output | 1 | Sticky unsupported little-endian request flag |

## Verification
The bench builds the block with its default parameters: a 16-bit port address, the standard port numbers and the 32-bit status word at 0xBFFFEFF0. With these values, random addresses drawn mostly from the decoded port list reach every register, strap, keylock and write-only path. Random 16-bit addresses cover the unmapped space. Memory reads are steered between the exact window address, a nearby address and partial byte enables, and the strap inputs are re-drawn after each reset. A rarely set little-endian bit lets the sticky flag be seen both clear and set within one reset epoch.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  localparam int REG_W = 8;

  // big-endian numbering: architectural bit n is byte bit 7-n
  function automatic logic [REG_W-1:0] arch_bit(input int n);
    arch_bit = 8'(1) << (7 - n);
  endfunction

  localparam logic [REG_W-1:0] SR_MASK  = arch_bit(7);
  localparam logic [REG_W-1:0] LE_MASK  = arch_bit(6);
  localparam logic [REG_W-1:0] SC_MASK  = arch_bit(0) | arch_bit(1) | arch_bit(2) | arch_bit(3);
  localparam logic [REG_W-1:0] MAP_MASK = arch_bit(7);
  localparam logic [REG_W-1:0] RD_NONE  = '1;

  typedef struct packed {
    logic rst92;
    logic sysctl;
    logic iomap;
    logic equip;
    logic board;
    logic keylock;
    logic wonly;
  } port_sel_t;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_WO   = 4,
  parameter logic [ADDR_W-1:0] P_RESET = 16'h0092,
  parameter logic [ADDR_W-1:0] P_SYSCTL = 16'h081C,
  parameter logic [ADDR_W-1:0] P_IOMAP = 16'h0850,
  parameter logic [ADDR_W-1:0] P_EQUIP = 16'h080C,
  parameter logic [ADDR_W-1:0] P_BOARD = 16'h0852,
  parameter logic [ADDR_W-1:0] P_KEY = 16'h0818,
  parameter logic [N_WO-1:0][ADDR_W-1:0] P_WONLY = {16'h0814, 16'h0812, 16'h0810, 16'h0808}
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_t         sel
);

  logic [N_WO-1:0] wo_match;

  for (genvar i = 0; i < N_WO; i++) begin : g_wo
    assign wo_match[i] = (addr == P_WONLY[i]);
  end

  always_comb begin
    sel.rst92   = (addr == P_RESET);
    sel.sysctl  = (addr == P_SYSCTL);
    sel.iomap   = (addr == P_IOMAP);
    sel.equip   = (addr == P_EQUIP);
    sel.board   = (addr == P_BOARD);
    sel.keylock = (addr == P_KEY);
    sel.wonly   = |wo_match;
  end

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
  import sysio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  port_sel_t        sel,
  output logic             sr_q,
  output logic [REG_W-1:0] sc_q,
  output logic             map_q,
  output logic             le_q
);

  logic             sr_en, sc_en, map_en, le_en;
  logic             sr_d, map_d, le_d;
  logic [REG_W-1:0] sc_d;

  always_comb begin
    sr_en  = wr & sel.rst92;
    sc_en  = wr & sel.sysctl;
    map_en = wr & sel.iomap;
    le_en  = sr_en & (|(wdata & LE_MASK));
    sr_d   = |(wdata & SR_MASK);
    sc_d   = wdata & SC_MASK;
    map_d  = |(wdata & MAP_MASK);
    le_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= 1'b0;
      sc_q  <= '0;
      map_q <= 1'b1;
      le_q  <= 1'b0;
    end else begin
      if (sr_en)  sr_q  <= sr_d;
      if (sc_en)  sc_q  <= sc_d;
      if (map_en) map_q <= map_d;
      if (le_en)  le_q  <= le_d;
    end
  end

endmodule

// File: rtl/sysio_rd_mux.sv
module sysio_rd_mux
  import sysio_pkg::*;
(
  input  logic             rd,
  input  port_sel_t        sel,
  input  logic             sr_q,
  input  logic [REG_W-1:0] sc_q,
  input  logic             map_q,
  input  logic [REG_W-1:0] cfg_equip,
  input  logic [REG_W-1:0] cfg_board_id,
  output logic [REG_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (sel.rst92)        rdata = {{(REG_W-1){1'b0}}, sr_q};
      else if (sel.sysctl)  rdata = sc_q;
      else if (sel.iomap)   rdata = {{(REG_W-1){1'b0}}, map_q};
      else if (sel.equip)   rdata = cfg_equip;
      else if (sel.board)   rdata = cfg_board_id;
      else if (sel.keylock) rdata = '0;
      else                  rdata = RD_NONE;
    end
  end

endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win #(
  parameter int MEM_AW = 32,
  parameter int BYTES  = 4,
  parameter logic [MEM_AW-1:0] BASE = 32'hBFFF_EFF0
) (
  input  logic              mem_rd,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [BYTES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_hit
);

  localparam int DATA_W = BYTES * 8;

  always_comb begin
    mem_hit   = mem_rd & (mem_addr == BASE) & (&mem_be);
    mem_rdata = '0;
  end

endmodule

// File: rtl/sysio_regbank.sv
module sysio_regbank
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 32,
  parameter int MEM_BYTES = 4,
  parameter logic [MEM_AW-1:0] PARITY_BASE = 32'hBFFF_EFF0,
  parameter logic [ADDR_W-1:0] P_RESET = 16'h0092,
  parameter logic [ADDR_W-1:0] P_SYSCTL = 16'h081C,
  parameter logic [ADDR_W-1:0] P_IOMAP = 16'h0850,
  parameter logic [ADDR_W-1:0] P_EQUIP = 16'h080C,
  parameter logic [ADDR_W-1:0] P_BOARD = 16'h0852,
  parameter logic [ADDR_W-1:0] P_KEY = 16'h0818
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_rd,
  input  logic                   io_wr,
  input  logic [REG_W-1:0]       io_wdata,
  output logic [REG_W-1:0]       io_rdata,
  input  logic [REG_W-1:0]       cfg_equip,
  input  logic [REG_W-1:0]       cfg_board_id,
  input  logic [MEM_AW-1:0]      mem_addr,
  input  logic                   mem_rd,
  input  logic [MEM_BYTES-1:0]   mem_be,
  output logic [MEM_BYTES*8-1:0] mem_rdata,
  output logic                   mem_hit,
  output logic                   soft_rst,
  output logic                   map_noncontig,
  output logic                   le_err
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  port_sel_t              sel;
  logic                   sr_q, map_q, le_q;
  logic [REG_W-1:0]       sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  sysio_decode #(
    .ADDR_W(ADDR_W), .P_RESET(P_RESET), .P_SYSCTL(P_SYSCTL), .P_IOMAP(P_IOMAP),
    .P_EQUIP(P_EQUIP), .P_BOARD(P_BOARD), .P_KEY(P_KEY)
  ) u_decode (
    .addr(io_addr),
    .sel (sel)
  );

  sysio_ctrl_regs u_regs (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr   (io_wr),
    .wdata(io_wdata),
    .sel  (sel),
    .sr_q (sr_q),
    .sc_q (sc_q),
    .map_q(map_q),
    .le_q (le_q)
  );

  sysio_rd_mux u_rdmux (
    .rd          (io_rd),
    .sel         (sel),
    .sr_q        (sr_q),
    .sc_q        (sc_q),
    .map_q       (map_q),
    .cfg_equip   (cfg_equip),
    .cfg_board_id(cfg_board_id),
    .rdata       (io_rdata)
  );

  sysio_parity_win #(
    .MEM_AW(MEM_AW), .BYTES(MEM_BYTES), .BASE(PARITY_BASE)
  ) u_parity (
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_rdata(mem_rdata),
    .mem_hit  (mem_hit)
  );

  assign soft_rst      = sr_q;
  assign map_noncontig = map_q;
  assign le_err        = le_q;

endmodule

// File: rtl/sysio_regbank_chk.sv
module sysio_regbank_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] P_RESET = 16'h0092,
  parameter logic [ADDR_W-1:0] P_SYSCTL = 16'h081C,
  parameter logic [ADDR_W-1:0] P_IOMAP = 16'h0850,
  parameter logic [ADDR_W-1:0] P_KEY = 16'h0818
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [31:0]       mem_rdata,
  input logic              mem_hit,
  input logic              soft_rst,
  input logic              map_noncontig,
  input logic              le_err
);

  // R2
  soft_rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P_RESET) |=> (soft_rst == $past(io_wdata[0])));

  // R3
  le_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P_RESET && io_wdata[1]) |=> le_err);

  // R3
  le_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_err |=> le_err);

  // R4
  sysctl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == P_SYSCTL) |-> (io_rdata[3:0] == 4'h0));

  // R5
  map_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P_IOMAP) |=> (map_noncontig == $past(io_wdata[0])));

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == P_IOMAP) |=> $stable(map_noncontig));

  // R7
  keylock_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == P_KEY) |-> (io_rdata == 8'h00));

  // R10
  parity_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> (mem_rdata == 32'h0));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));

endmodule

bind sysio_regbank sysio_regbank_chk #(
  .ADDR_W(ADDR_W), .P_RESET(P_RESET), .P_SYSCTL(P_SYSCTL),
  .P_IOMAP(P_IOMAP), .P_KEY(P_KEY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .io_addr      (io_addr),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .mem_rdata    (mem_rdata),
  .mem_hit      (mem_hit),
  .soft_rst     (soft_rst),
  .map_noncontig(map_noncontig),
  .le_err       (le_err)
);

// File: tb/sysio_regbank_bench.sv
`timescale 1ns/1ps
module sysio_regbank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata, io_rdata, cfg_equip, cfg_board_id;
  logic [31:0] mem_addr, mem_rdata;
  logic        mem_rd, mem_hit;
  logic [3:0]  mem_be;
  logic        soft_rst, map_noncontig, le_err;

  int checks = 0;
  int fails  = 0;

  logic       m_sr, m_map, m_le;
  logic [7:0] m_sc;

  localparam logic [15:0] PORTS [10] = '{16'h0092, 16'h081C, 16'h0850, 16'h080C, 16'h0852,
                                         16'h0818, 16'h0808, 16'h0810, 16'h0812, 16'h0814};

  always #2.5 clk = ~clk;

  sysio_regbank u_sysio_regbank (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_equip(cfg_equip),
    .cfg_board_id(cfg_board_id), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_hit(mem_hit),
    .soft_rst(soft_rst), .map_noncontig(map_noncontig), .le_err(le_err)
  );

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h0092: exp_rd = {7'b0, m_sr};
      16'h081C: exp_rd = m_sc;
      16'h0850: exp_rd = {7'b0, m_map};
      16'h080C: exp_rd = cfg_equip;
      16'h0852: exp_rd = cfg_board_id;
      16'h0818: exp_rd = 8'h00;
      default:  exp_rd = 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'h0092: tag_of = "R2";
      16'h081C: tag_of = "R4";
      16'h0850: tag_of = "R5";
      16'h080C, 16'h0852: tag_of = "R6";
      16'h0818: tag_of = "R7";
      16'h0808, 16'h0810, 16'h0812, 16'h0814: tag_of = "R8";
      default:  tag_of = "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = 1'b0; m_map = 1'b1; m_le = 1'b0; m_sc = 8'h00;
  endtask

  task automatic idle();
    io_rd = 0; io_wr = 0; io_addr = '0; io_wdata = '0;
    mem_rd = 0; mem_addr = '0; mem_be = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    model_reset();
    cfg_equip = 8'($urandom); cfg_board_id = 8'($urandom);
    #1;
    check("R1", {29'b0, soft_rst, map_noncontig, le_err}, {29'b0, 3'b010});
    io_rd = 1; io_addr = 16'h0850; #0.5;
    check("R1", io_rdata, 8'h01);
    io_addr = 16'h0092; #0.5;
    check("R1", io_rdata, 8'h00);
    io_addr = 16'h081C; #0.5;
    check("R1", io_rdata, 8'h00);
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {29'b0, soft_rst, map_noncontig, le_err}, {29'b0, 3'b010});
  endtask

  task automatic step(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d);
    logic exp_hit;
    @(negedge clk);
    check("R2", soft_rst, m_sr);
    check("R5", map_noncontig, m_map);
    check("R3", le_err, m_le);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    mem_rd = 1'($urandom);
    case ($urandom % 3)
      0: mem_addr = 32'hBFFF_EFF0;
      1: mem_addr = 32'hBFFF_EFF0 + 32'($urandom % 8);
      default: mem_addr = $urandom;
    endcase
    mem_be = ($urandom % 2) ? 4'hF : 4'($urandom);
    #1;
    if (rd) check(tag_of(a), io_rdata, exp_rd(a));
    else    check("R11", io_rdata, 8'h00);
    exp_hit = mem_rd && mem_addr == 32'hBFFF_EFF0 && mem_be == 4'hF;
    check("R10", mem_hit, exp_hit);
    check("R10", mem_rdata, 32'h0);
    if (wr) begin
      case (a)
        16'h0092: begin m_sr = d[0]; if (d[1]) m_le = 1'b1; end
        16'h081C: m_sc = d & 8'hF0;
        16'h0850: m_map = d[0];
        default: ;
      endcase
    end
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    idle();
    cfg_equip = '0; cfg_board_id = '0;
    rst_n = 1'b0;
    model_reset();
    do_reset();

    // directed: R2 set then read back, R3 request, R4 mask, R5 clear
    step(16'h0092, 0, 1, 8'h01);
    step(16'h0092, 1, 0, 8'h00);
    step(16'h081C, 0, 1, 8'hFF);
    step(16'h081C, 1, 0, 8'h00);
    step(16'h0850, 0, 1, 8'hFE);
    step(16'h0850, 1, 1, 8'h01);
    step(16'h0814, 0, 1, 8'hFF);
    step(16'h0808, 1, 0, 8'h00);
    step(16'h1234, 1, 1, 8'h03);
    step(16'h0092, 0, 1, 8'h03);
    step(16'h0092, 1, 0, 8'h00);
    step(16'h0092, 0, 1, 8'h00);

    for (int ep = 0; ep < 6; ep++) begin
      do_reset();
      for (int i = 0; i < 400; i++) begin
        logic [15:0] a;
        logic [7:0]  d;
        a = ($urandom % 12 < 10) ? PORTS[$urandom % 10] : 16'($urandom);
        d = 8'($urandom);
        if (a == 16'h0092 && ($urandom % 8) != 0) d[1] = 1'b0;
        step(a, 1'($urandom), ($urandom % 3) == 0, d);
      end
    end
    step(16'h0000, 0, 0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule